// File: doc/BRIEF.md
# Redriver Lane Control Register Block

This block is the byte-wide control register file of a four-lane DisplayPort linear redriver. Software reaches it through a simple register bus with an address, write data, a write strobe, a read strobe and registered read data. Its sideband inputs are:

- a sampled 4-bit equalization pin code with a capture strobe;
- two candidate hot-plug-detect (HPD) pin levels;
- snooped link-training values: the lane count and the power state, each with its own capture strobe.

From these registers and inputs the block drives a registered per-lane enable vector, a 4-bit equalization setting for each lane, the effective HPD level, the operating mode and a 2-bit output-swing code.

Lane enables come from one of two sources. In snoop mode they are decoded from the snooped lane count, and the snooped power state gates that decode. In register mode, per-lane disable bits set them directly. In either case a lane can only be on while the mode is DisplayPort-enabled.

Equalization fields have two owners. When the override bit is clear, the pin code owns them. When it is set, software owns them. Readback always shows the value that drives the lanes. The snooped status fields are cleared by hardware whenever the upper mode bit falls.

Top module: `redrv_lane_ctl`

## Requirements
- R1: After a synchronous reset, the following hold: general register (0x0A) reads 0x01, swing register (0x32) reads 0x40, lane control (0x13) and snoop status (0x12) read 0x00, lane_en is 0, mode_o is 1, swing_o is 0, lane_eq is 0.
- R2: Only offsets 0x0A, 0x10, 0x11, 0x12, 0x13 and 0x32 are decoded. A read of any other offset returns 0x00, and a write to any other offset changes no register.
- R3: General register bits 1:0 are the mode (0 off, 1 idle, 2 DisplayPort, 3 reserved) and drive mode_o. lane_en is all zero whenever the mode is not 2. Bit 6 reads 0. Bits 7, 5, 4, 3, 2 are read/write.
- R4: With the override bit (general bit 4) at 0, an eq_pin_stb loads eq_pin_val into all four lane fields, and software writes to 0x10/0x11 are ignored.
- R5: With the override bit at 1, writes to 0x10 set lane 1 (bits 7:4) and lane 0 (bits 3:0), and writes to 0x11 set lane 3 (bits 7:4) and lane 2 (bits 3:0). eq_pin_stb is ignored. Lane i drives lane_eq[4i+3:4i].
- R6: hpd_eff is registered and equals 1 when general bit 3 is set. Otherwise it equals hpd_pin_b when general bit 5 is set and hpd_pin_a when bit 5 is clear.
- R7: Snoop status (0x12) is read-only. Bits 6:5 hold the last captured power state, bits 4:0 hold the last captured lane count, and bit 7 reads 0. Capture strobes are ignored unless the mode is 2.
- R8: A write to the general register that takes mode bit 1 from 1 to 0 clears both snoop status fields at the same clock edge.
- R9: In snoop mode (lane control bit 7 = 0) with mode 2, lane counts of 1, 2 and 4 enable lanes {0}, {0,1} and {0..3}. Every other count enables no lane.
- R10: In snoop mode, a captured power state of 2 disables all lanes regardless of the lane count. Any other power-state value lets the count decode through.
- R11: With lane control bit 7 = 1 and mode 2, bits 3:0 act as per-lane disables for lanes 3..0 (1 = disabled). While bit 7 = 0, these bits have no effect on lane_en. Bit 6 reads 0.
- R12: Swing register bits 5:4 drive swing_o (0 highest linearity level, 3 lowest). Bits 7:6 reset to 1. All bits except none are read/write.
- R13: lane_en updates exactly one clock after its controlling state changes. bus_rdata is loaded on the clock edge at which bus_rd is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| eq_pin_val | input | 4 | Sampled equalization pin code |
| eq_pin_stb | input | 1 | Capture strobe for eq_pin_val |
| hpd_pin_a | input | 1 | Default HPD pin level |
| hpd_pin_b | input | 1 | Alternate HPD pin level |
| snp_cnt | input | 5 | Snooped lane count |
| snp_cnt_stb | input | 1 | Capture strobe for snp_cnt |
| snp_pwr | input | 2 | Snooped power state |
| snp_pwr_stb | input | 1 | Capture strobe for snp_pwr |
| lane_en | output | 4 | Per-lane enable, bit i for lane i |
| lane_eq | output | 16 | Per-lane equalization, 4 bits per lane |
| hpd_eff | output | 1 | Effective HPD level |
| mode_o | output | 2 | Current mode field |
| swing_o | output | 2 | Output swing linearity code |

## Verification
A corrupted mode or snoop field shows on lane_en one clock after the faulty value is stored, because every lane enable is recomputed from the registered state on each edge. A wrong equalization owner shows up in two places at once: in the lane_eq output right after the offending strobe or write, and in the 0x10/0x11 readback, because both come from the same lane registers. A missed clear of the snoop fields is visible at the next 0x12 read. It also shows on lane_en as soon as the mode returns to 2.

// File: rtl/redrv_pkg.sv
package redrv_pkg;
  localparam int NUM_LANES = 4;
  localparam int EQ_W      = 4;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int CNT_W     = 5;
  localparam int PWR_W     = 2;
  localparam int EQ_REGS   = NUM_LANES / 2;

  localparam logic [ADDR_W-1:0] OFF_GEN   = 8'h0A;
  localparam logic [ADDR_W-1:0] OFF_EQ01  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_EQ23  = 8'h11;
  localparam logic [ADDR_W-1:0] OFF_SNP   = 8'h12;
  localparam logic [ADDR_W-1:0] OFF_LCTL  = 8'h13;
  localparam logic [ADDR_W-1:0] OFF_SWING = 8'h32;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_DP   = 2'd2,
    MODE_RSV  = 2'd3
  } mode_e;

  localparam logic [PWR_W-1:0] PWR_DOWN = 2'd2;

  // Lane count decode: only 1, 2 and 4 are legal widths; lanes below the count turn on.
  function automatic logic [NUM_LANES-1:0] count_to_mask(input logic [CNT_W-1:0] cnt);
    logic [NUM_LANES-1:0] m;
    logic ok;
    ok = (cnt == 5'd1) || (cnt == 5'd2) || (cnt == 5'd4);
    for (int i = 0; i < NUM_LANES; i++) begin
      m[i] = ok && (i < int'(cnt));
    end
    return m;
  endfunction
endpackage

// File: rtl/redrv_eq_bank.sv
module redrv_eq_bank
  import redrv_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sw_own,
  input  logic                      pin_stb,
  input  logic [EQ_W-1:0]           pin_val,
  input  logic [EQ_REGS-1:0]        reg_wr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NUM_LANES*EQ_W-1:0] eq_flat
);
  localparam int PER_REG = DATA_W / EQ_W;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [EQ_W-1:0] eq_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        eq_q <= '0;
      end else if (sw_own) begin
        if (reg_wr[i / PER_REG]) eq_q <= wdata[EQ_W*(i % PER_REG) +: EQ_W];
      end else if (pin_stb) begin
        eq_q <= pin_val;
      end
    end
    assign eq_flat[EQ_W*i +: EQ_W] = eq_q;
  end

  // R4: pin-owned fields move only on a pin strobe
  a_r4_pin_owned_hold: assert property (@(posedge clk) disable iff (rst)
    (!sw_own && !pin_stb) |=> $stable(eq_flat));
  // R5: software-owned fields move only on a register write
  a_r5_sw_owned_hold: assert property (@(posedge clk) disable iff (rst)
    (sw_own && reg_wr == '0) |=> $stable(eq_flat));
endmodule

// File: rtl/redrv_lane_gate.sv
module redrv_lane_gate
  import redrv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode,
  input  logic                 snp_off,
  input  logic [NUM_LANES-1:0] lane_dis,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [PWR_W-1:0]     pwr,
  output logic [NUM_LANES-1:0] lane_en
);
  logic [NUM_LANES-1:0] snoop_mask;
  logic [NUM_LANES-1:0] next_en;

  always_comb begin
    snoop_mask = (pwr == PWR_DOWN) ? '0 : count_to_mask(cnt);
    if (mode != MODE_DP) next_en = '0;
    else if (snp_off)    next_en = ~lane_dis;
    else                 next_en = snoop_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) lane_en <= '0;
    else     lane_en <= next_en;
  end

  // R3: no lane outside DisplayPort mode
  a_r3_off_outside_dp: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_DP) |=> (lane_en == '0));
  // R10: power-down snoop value shuts every lane
  a_r10_power_down: assert property (@(posedge clk) disable iff (rst)
    (!snp_off && pwr == PWR_DOWN) |=> (lane_en == '0));
  // R9: only legal lane patterns in snoop mode
  a_r9_legal_pattern: assert property (@(posedge clk) disable iff (rst)
    (!snp_off) |=> (lane_en == 4'h0 || lane_en == 4'h1 || lane_en == 4'h3 || lane_en == 4'hF));
endmodule

// File: rtl/redrv_lane_ctl.sv
module redrv_lane_ctl
  import redrv_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [EQ_W-1:0]           eq_pin_val,
  input  logic                      eq_pin_stb,
  input  logic                      hpd_pin_a,
  input  logic                      hpd_pin_b,
  input  logic [CNT_W-1:0]          snp_cnt,
  input  logic                      snp_cnt_stb,
  input  logic [PWR_W-1:0]          snp_pwr,
  input  logic                      snp_pwr_stb,
  output logic [NUM_LANES-1:0]      lane_en,
  output logic [NUM_LANES*EQ_W-1:0] lane_eq,
  output logic                      hpd_eff,
  output logic [1:0]                mode_o,
  output logic [1:0]                swing_o
);
  // general register fields
  logic       gen_b7_q, hpd_sel_q, eq_sw_q, hpd_force_q, gen_b2_q;
  logic [1:0] mode_q;
  // lane control fields
  logic                 snp_off_q;
  logic [1:0]           lc_rsv_q;
  logic [NUM_LANES-1:0] lane_dis_q;
  // swing register fields
  logic [1:0] sw_hi_q, swing_q;
  logic [3:0] sw_lo_q;
  // snoop status
  logic [CNT_W-1:0] snp_cnt_q;
  logic [PWR_W-1:0] snp_pwr_q;

  logic wr_gen, wr_lctl, wr_swing, mode_fall, dp_on;
  logic [EQ_REGS-1:0] wr_eq;
  logic [DATA_W-1:0]  rd_mux;

  assign wr_gen    = bus_wr && (bus_addr == OFF_GEN);
  assign wr_lctl   = bus_wr && (bus_addr == OFF_LCTL);
  assign wr_swing  = bus_wr && (bus_addr == OFF_SWING);
  assign wr_eq     = {bus_wr && (bus_addr == OFF_EQ23), bus_wr && (bus_addr == OFF_EQ01)};
  assign mode_fall = wr_gen && mode_q[1] && !bus_wdata[1];
  assign dp_on     = (mode_q == MODE_DP);

  always_ff @(posedge clk) begin
    if (rst) begin
      {gen_b7_q, hpd_sel_q, eq_sw_q, hpd_force_q, gen_b2_q} <= '0;
      mode_q <= MODE_IDLE;
    end else if (wr_gen) begin
      gen_b7_q    <= bus_wdata[7];
      hpd_sel_q   <= bus_wdata[5];
      eq_sw_q     <= bus_wdata[4];
      hpd_force_q <= bus_wdata[3];
      gen_b2_q    <= bus_wdata[2];
      mode_q      <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_off_q  <= 1'b0;
      lc_rsv_q   <= '0;
      lane_dis_q <= '0;
    end else if (wr_lctl) begin
      snp_off_q  <= bus_wdata[7];
      lc_rsv_q   <= bus_wdata[5:4];
      lane_dis_q <= bus_wdata[NUM_LANES-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_hi_q <= 2'd1;
      swing_q <= '0;
      sw_lo_q <= '0;
    end else if (wr_swing) begin
      sw_hi_q <= bus_wdata[7:6];
      swing_q <= bus_wdata[5:4];
      sw_lo_q <= bus_wdata[3:0];
    end
  end

  // snoop capture: clear on mode bit 1 falling wins over capture
  always_ff @(posedge clk) begin
    if (rst || mode_fall) begin
      snp_cnt_q <= '0;
      snp_pwr_q <= '0;
    end else if (dp_on) begin
      if (snp_cnt_stb) snp_cnt_q <= snp_cnt;
      if (snp_pwr_stb) snp_pwr_q <= snp_pwr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hpd_eff <= 1'b0;
    else     hpd_eff <= hpd_force_q | (hpd_sel_q ? hpd_pin_b : hpd_pin_a);
  end

  redrv_eq_bank u_eq (
    .clk     (clk),
    .rst     (rst),
    .sw_own  (eq_sw_q),
    .pin_stb (eq_pin_stb),
    .pin_val (eq_pin_val),
    .reg_wr  (wr_eq),
    .wdata   (bus_wdata),
    .eq_flat (lane_eq)
  );

  redrv_lane_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_q),
    .snp_off  (snp_off_q),
    .lane_dis (lane_dis_q),
    .cnt      (snp_cnt_q),
    .pwr      (snp_pwr_q),
    .lane_en  (lane_en)
  );

  always_comb begin
    case (bus_addr)
      OFF_GEN:   rd_mux = {gen_b7_q, 1'b0, hpd_sel_q, eq_sw_q, hpd_force_q, gen_b2_q, mode_q};
      OFF_EQ01:  rd_mux = lane_eq[7:0];
      OFF_EQ23:  rd_mux = lane_eq[15:8];
      OFF_SNP:   rd_mux = {1'b0, snp_pwr_q, snp_cnt_q};
      OFF_LCTL:  rd_mux = {snp_off_q, 1'b0, lc_rsv_q, lane_dis_q};
      OFF_SWING: rd_mux = {sw_hi_q, swing_q, sw_lo_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign mode_o  = mode_q;
  assign swing_o = swing_q;

  // R8: falling mode bit 1 clears the snoop status
  a_r8_snoop_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_GEN && mode_o[1] && !bus_wdata[1]) |=> (snp_cnt_q == '0 && snp_pwr_q == '0));
  // R7: no capture outside DisplayPort mode
  a_r7_no_capture_off: assert property (@(posedge clk) disable iff (rst)
    (mode_o != MODE_DP) |=> $stable(snp_cnt_q) || (snp_cnt_q == '0));
  // R6: forced HPD reads high one clock later
  a_r6_hpd_force: assert property (@(posedge clk) disable iff (rst)
    hpd_force_q |=> hpd_eff);
  // R2: undecoded offsets read zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr != OFF_GEN && bus_addr != OFF_EQ01 && bus_addr != OFF_EQ23 &&
     bus_addr != OFF_SNP && bus_addr != OFF_LCTL && bus_addr != OFF_SWING) |=> (bus_rdata == '0));
endmodule

// File: tb/redrv_lane_ctl_tb.sv
module redrv_lane_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  eq_pin_val = '0;
  logic        eq_pin_stb = 1'b0;
  logic        hpd_pin_a = 1'b1, hpd_pin_b = 1'b0;
  logic [4:0]  snp_cnt = '0;
  logic        snp_cnt_stb = 1'b0;
  logic [1:0]  snp_pwr = '0;
  logic        snp_pwr_stb = 1'b0;
  logic [3:0]  lane_en;
  logic [15:0] lane_eq;
  logic        hpd_eff;
  logic [1:0]  mode_o, swing_o;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  redrv_lane_ctl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .eq_pin_val(eq_pin_val), .eq_pin_stb(eq_pin_stb),
    .hpd_pin_a(hpd_pin_a), .hpd_pin_b(hpd_pin_b), .snp_cnt(snp_cnt), .snp_cnt_stb(snp_cnt_stb),
    .snp_pwr(snp_pwr), .snp_pwr_stb(snp_pwr_stb), .lane_en(lane_en), .lane_eq(lane_eq),
    .hpd_eff(hpd_eff), .mode_o(mode_o), .swing_o(swing_o)
  );

  // {addr, wdata, expected readback, requirement number}
  localparam logic [31:0] VEC [12] = '{
    {8'h32, 8'hFF, 8'hFF, 8'd12},
    {8'h32, 8'h25, 8'h25, 8'd12},
    {8'h13, 8'hFF, 8'hBF, 8'd11},
    {8'h13, 8'h00, 8'h00, 8'd11},
    {8'h0A, 8'hFF, 8'hBF, 8'd3},
    {8'h0A, 8'h02, 8'h02, 8'd3},
    {8'h12, 8'hFF, 8'h00, 8'd7},
    {8'h20, 8'hAA, 8'h00, 8'd2},
    {8'h10, 8'h5A, 8'h00, 8'd4},
    {8'h0A, 8'h12, 8'h12, 8'd5},
    {8'h10, 8'h5A, 8'h5A, 8'd5},
    {8'h11, 8'hC3, 8'hC3, 8'd5}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic snoop(input logic [4:0] c, input logic [1:0] p);
    @(negedge clk); snp_cnt = c; snp_pwr = p; snp_cnt_stb = 1'b1; snp_pwr_stb = 1'b1;
    @(negedge clk); snp_cnt_stb = 1'b0; snp_pwr_stb = 1'b0;
  endtask

  task automatic pin_eq(input logic [3:0] v);
    @(negedge clk); eq_pin_val = v; eq_pin_stb = 1'b1;
    @(negedge clk); eq_pin_stb = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 lane_en", lane_en, 0);
    chk("R1 mode_o", mode_o, 1);
    chk("R1 swing_o", swing_o, 0);
    chk("R1 lane_eq", lane_eq, 0);
    chk("R6 hpd pin a", hpd_eff, 1);
    rd(8'h0A, d); chk("R1 general", d, 8'h01);
    rd(8'h32, d); chk("R1 R12 swing reg", d, 8'h40);
    rd(8'h13, d); chk("R1 lane ctl", d, 8'h00);

    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][31:24], VEC[i][23:16]);
      rd(VEC[i][31:24], d);
      chk($sformatf("R%0d vec%0d", VEC[i][7:0], i), d, VEC[i][15:8]);
    end
    chk("R5 lane_eq out", lane_eq, 16'hC35A);
    chk("R12 swing_o", swing_o, 2);
    chk("R3 mode_o", mode_o, 2);
    rd(8'h32, d); chk("R2 reserved write no effect", d, 8'h25);

    pin_eq(4'h7);
    rd(8'h10, d); chk("R5 pin strobe ignored", d, 8'h5A);
    wr(8'h0A, 8'h02);
    pin_eq(4'h9);
    rd(8'h10, d); chk("R4 eq01 from pins", d, 8'h99);
    rd(8'h11, d); chk("R4 eq23 from pins", d, 8'h99);
    chk("R4 lane_eq from pins", lane_eq, 16'h9999);
    wr(8'h10, 8'h12);
    rd(8'h10, d); chk("R4 sw write ignored", d, 8'h99);

    wr(8'h0A, 8'h22); @(negedge clk);
    chk("R6 hpd pin b", hpd_eff, 0);
    wr(8'h0A, 8'h2A); @(negedge clk);
    chk("R6 hpd forced", hpd_eff, 1);
    wr(8'h0A, 8'h02);
    hpd_pin_a = 1'b0; repeat (2) @(negedge clk);
    chk("R6 hpd follows pin a", hpd_eff, 0);
    hpd_pin_a = 1'b1;

    snoop(5'd4, 2'd1); @(negedge clk);
    chk("R9 count 4", lane_en, 4'hF);
    rd(8'h12, d); chk("R7 status layout", d, 8'h24);
    snoop(5'd2, 2'd1); @(negedge clk); chk("R9 count 2", lane_en, 4'h3);
    snoop(5'd1, 2'd1); @(negedge clk); chk("R9 count 1", lane_en, 4'h1);
    snoop(5'd3, 2'd1); @(negedge clk); chk("R9 count 3", lane_en, 4'h0);
    snoop(5'd0, 2'd1); @(negedge clk); chk("R9 count 0", lane_en, 4'h0);
    snoop(5'd4, 2'd2); @(negedge clk); chk("R10 power down", lane_en, 4'h0);
    snoop(5'd4, 2'd1);
    chk("R13 lane_en not yet", lane_en, 4'h0);
    @(negedge clk); chk("R13 lane_en one clock later", lane_en, 4'hF);

    wr(8'h13, 8'h05); @(negedge clk);
    chk("R11 disables ignored in snoop", lane_en, 4'hF);
    wr(8'h13, 8'h85); @(negedge clk);
    chk("R11 register disables", lane_en, 4'hA);
    rd(8'h13, d); chk("R11 lane ctl read", d, 8'h85);
    wr(8'h13, 8'h00); @(negedge clk);
    chk("R11 back to snoop", lane_en, 4'hF);

    wr(8'h0A, 8'h03); @(negedge clk);
    chk("R3 mode 3 lanes off", lane_en, 4'h0);
    rd(8'h12, d); chk("R8 no clear when bit1 stays", d, 8'h24);
    wr(8'h0A, 8'h01);
    rd(8'h12, d); chk("R8 status cleared", d, 8'h00);
    chk("R3 mode 1 lanes off", lane_en, 4'h0);
    snoop(5'd4, 2'd1);
    rd(8'h12, d); chk("R7 capture ignored off-mode", d, 8'h00);
    wr(8'h13, 8'h80); @(negedge clk);
    chk("R3 register mode still off", lane_en, 4'h0);
    wr(8'h0A, 8'h02);
    chk("R13 enable waits a clock", lane_en, 4'h0);
    @(negedge clk); chk("R11 all lanes on", lane_en, 4'hF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule